// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block watches write cycles on a parallel byte-wide memory bus and turns multi-cycle command sequences into single-clock command pulses. A command opens with a fixed two-write unlock prefix (0xAA to address 0x5555, then 0x55 to address 0x2AAA). The third write, and for the long commands the fourth to sixth writes, select one of five commands: byte program, chip erase, boot-area lockout enable, identification-mode entry or identification-mode exit. For byte program the block also hands over the target address and data taken from the fourth write.

All bus inputs are sampled on the system clock. The combined strobe is active when chip enable and write enable are both low while output enable is high. It must stay active for a parameterised number of clocks before the write counts, which rejects short glitches. The address is taken when the combined strobe starts, which is the later of the two falling edges. The data is taken from the last active sample, which is the earlier of the two rising edges. Any write that does not fit the sequence sends the matcher back to idle. A write that arrives while the downstream program/erase controller reports busy is dropped, and the matcher also returns to idle.

Top module: `cmd_seq_decoder`

## Requirements
- R1: A write is counted only while ce_n=0, we_n=0 and oe_n=1 hold together. A strobe with oe_n=0, or with ce_n=1, is not a write and leaves the sequence where it was.
- R2: The combined strobe must stay active for at least FILT_CYCLES consecutive clocks (default 3). A shorter strobe is not a write and does not disturb a sequence in progress.
- R3: The write address is the bus address at the first clock of the combined strobe. The write data is the bus data at its last active clock.
- R4: The writes AA@5555, 55@2AAA, A0@5555 and then any address/data pair produce one pgm_pulse. pgm_addr carries the full ADDR_W address and pgm_data carries the data of the fourth write.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 10@5555 produce one erase_pulse.
- R6: The same five-write prefix as R5 followed by 40@5555 produces one lock_pulse.
- R7: The writes AA@5555, 55@2AAA and 90@5555 produce one id_enter_pulse and set id_mode to 1.
- R8: id_mode is cleared with one id_exit_pulse by the writes AA@5555, 55@2AAA and F0@5555, or, while id_mode=1, by a single write of F0 to any address. A single F0 write while id_mode=0 gives no pulse.
- R9: A write that is not the expected next pair returns the matcher to idle with no pulse. The later writes of the broken sequence then give nothing.
- R10: Addresses are compared on bits 14:0 only. 0x35555 counts as 0x5555 and 0x3AAAA counts as 0x2AAA, but 0x01555 does not count as 0x5555.
- R11: A write accepted while busy=1 gives no pulse and returns the matcher to idle.
- R12: Every command pulse is exactly one clock wide, and at most one command pulse is high in any clock.
- R13: After reset all command pulses are low and id_mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus write data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Program/erase controller busy |
| pgm_pulse | output | 1 | Byte program command pulse |
| pgm_addr | output | ADDR_W | Target address of the program |
| pgm_data | output | DATA_W | Data to program |
| erase_pulse | output | 1 | Chip erase command pulse |
| lock_pulse | output | 1 | Boot-area lockout enable pulse |
| id_enter_pulse | output | 1 | Identification-mode entry pulse |
| id_exit_pulse | output | 1 | Identification-mode exit pulse |
| id_mode | output | 1 | Identification mode active |

## Verification
A matcher left in the wrong state gives no sign until the last write of a sequence. It then shows as a missing pulse, a wrong pulse, or a pulse after a sequence that should have been aborted. For that reason every test ends in a complete sequence, and each abort test finishes its broken sequence to prove that nothing fires. A wrong address or data latch point shows only on pgm_addr and pgm_data, two clocks after the strobe ends. The latch test therefore changes the bus inside the strobe and while the two strobes overlap. A missed id_mode update shows at once on id_mode, in the same clock as the entry or exit pulse.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

   localparam int MATCH_W = 15;
   localparam logic [MATCH_W-1:0] UNLOCK_A1 = 15'h5555;
   localparam logic [MATCH_W-1:0] UNLOCK_A2 = 15'h2AAA;

   localparam logic [7:0] CODE_UNL1  = 8'hAA;
   localparam logic [7:0] CODE_UNL2  = 8'h55;
   localparam logic [7:0] CODE_PGM   = 8'hA0;
   localparam logic [7:0] CODE_EXT   = 8'h80;
   localparam logic [7:0] CODE_IDIN  = 8'h90;
   localparam logic [7:0] CODE_IDOUT = 8'hF0;
   localparam logic [7:0] CODE_ERASE = 8'h10;
   localparam logic [7:0] CODE_LOCK  = 8'h40;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PGM_ARM,
      ST_EXT3,
      ST_EXT4,
      ST_EXT5
   } seq_state_t;

   typedef struct packed {
      logic at_a1;
      logic at_a2;
      logic d_unl1;
      logic d_unl2;
      logic d_pgm;
      logic d_ext;
      logic d_idin;
      logic d_idout;
      logic d_erase;
      logic d_lock;
   } pair_hit_t;

   typedef struct packed {
      logic pgm;
      logic erase;
      logic lock;
      logic id_enter;
      logic id_exit;
   } cmd_pulse_t;

endpackage

// File: rtl/cmd_strobe_qual.sv
module cmd_strobe_qual #(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 8,
   parameter int FILT_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int CNT_W = $clog2(FILT_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(FILT_CYCLES);

   generate
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("cmd_strobe_qual: FILT_CYCLES must be at least 1");
      end
   endgenerate

   logic              act_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] data_s;
   logic              first_s;
   logic              enough;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_s  <= 1'b0;
         addr_s <= '0;
         data_s <= '0;
      end else begin
         act_s  <= !ce_n && !we_n && oe_n;
         addr_s <= bus_addr;
         data_s <= bus_data;
      end
   end

   generate
      if (FILT_CYCLES == 1) begin : g_no_count
         logic seen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     seen <= 1'b0;
            else if (act_s) seen <= 1'b1;
            else            seen <= 1'b0;
         end
         assign first_s = act_s && !seen;
         assign enough  = seen;
      end else begin : g_count
         logic [CNT_W-1:0] run_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt <= '0;
            end else if (act_s) begin
               if (run_cnt != CNT_LIM) run_cnt <= run_cnt + 1'b1;
            end else begin
               run_cnt <= '0;
            end
         end
         assign first_s = act_s && (run_cnt == '0);
         assign enough  = (run_cnt == CNT_LIM);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= !act_s && enough;
         if (first_s) wr_addr <= addr_s;
         if (act_s)   wr_data <= data_s;
      end
   end

   AST_EVENT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);  // R2

   AST_EVENT_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !act_s);  // R1

endmodule

// File: rtl/cmd_pair_match.sv
module cmd_pair_match
   import cmd_seq_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output pair_hit_t         hit
);

   generate
      if (ADDR_W < MATCH_W) begin : g_bad_addr
         $error("cmd_pair_match: ADDR_W must cover the compared address bits");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("cmd_pair_match: DATA_W must be at least 8");
      end
   endgenerate

   logic [MATCH_W-1:0] low_addr;
   assign low_addr = wr_addr[MATCH_W-1:0];

   always_comb begin
      hit.at_a1   = (low_addr == UNLOCK_A1);
      hit.at_a2   = (low_addr == UNLOCK_A2);
      hit.d_unl1  = (wr_data == DATA_W'(CODE_UNL1));
      hit.d_unl2  = (wr_data == DATA_W'(CODE_UNL2));
      hit.d_pgm   = (wr_data == DATA_W'(CODE_PGM));
      hit.d_ext   = (wr_data == DATA_W'(CODE_EXT));
      hit.d_idin  = (wr_data == DATA_W'(CODE_IDIN));
      hit.d_idout = (wr_data == DATA_W'(CODE_IDOUT));
      hit.d_erase = (wr_data == DATA_W'(CODE_ERASE));
      hit.d_lock  = (wr_data == DATA_W'(CODE_LOCK));
   end

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
   import cmd_seq_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  pair_hit_t         hit,
   input  logic              busy,
   output cmd_pulse_t        pulse,
   output logic [ADDR_W-1:0] pgm_addr,
   output logic [DATA_W-1:0] pgm_data,
   output logic              id_mode
);

   seq_state_t state, st_nxt;
   cmd_pulse_t p_nxt;
   logic       id_nxt;
   logic       unl1_ok, unl2_ok, exit_ok;

   assign unl1_ok = hit.at_a1 && hit.d_unl1;
   assign unl2_ok = hit.at_a2 && hit.d_unl2;
   assign exit_ok = hit.d_idout && id_mode;

   always_comb begin
      st_nxt = state;
      p_nxt  = '0;
      id_nxt = id_mode;
      if (wr_valid && busy) begin
         st_nxt = ST_IDLE;
      end else if (wr_valid) begin
         st_nxt = ST_IDLE;
         unique case (state)
            ST_IDLE: begin
               if (unl1_ok)      st_nxt = ST_UNL1;
               else if (exit_ok) p_nxt.id_exit = 1'b1;
            end
            ST_UNL1: begin
               if (unl2_ok)      st_nxt = ST_UNL2;
               else if (exit_ok) p_nxt.id_exit = 1'b1;
            end
            ST_UNL2: begin
               if (hit.at_a1 && hit.d_pgm)       st_nxt = ST_PGM_ARM;
               else if (hit.at_a1 && hit.d_ext)  st_nxt = ST_EXT3;
               else if (hit.at_a1 && hit.d_idin) p_nxt.id_enter = 1'b1;
               else if (hit.d_idout && (hit.at_a1 || id_mode))
                  p_nxt.id_exit = 1'b1;
            end
            ST_PGM_ARM: p_nxt.pgm = 1'b1;
            ST_EXT3: begin
               if (unl1_ok)      st_nxt = ST_EXT4;
               else if (exit_ok) p_nxt.id_exit = 1'b1;
            end
            ST_EXT4: begin
               if (unl2_ok)      st_nxt = ST_EXT5;
               else if (exit_ok) p_nxt.id_exit = 1'b1;
            end
            ST_EXT5: begin
               if (hit.at_a1 && hit.d_erase)     p_nxt.erase = 1'b1;
               else if (hit.at_a1 && hit.d_lock) p_nxt.lock  = 1'b1;
               else if (exit_ok)                 p_nxt.id_exit = 1'b1;
            end
            default: st_nxt = ST_IDLE;
         endcase
         if (p_nxt.id_enter) id_nxt = 1'b1;
         if (p_nxt.id_exit)  id_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pulse    <= '0;
         id_mode  <= 1'b0;
         pgm_addr <= '0;
         pgm_data <= '0;
      end else begin
         state   <= st_nxt;
         pulse   <= p_nxt;
         id_mode <= id_nxt;
         if (p_nxt.pgm) begin
            pgm_addr <= wr_addr;
            pgm_data <= wr_data;
         end
      end
   end

   AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pulse));  // R12

   AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse != '0) |=> (pulse == '0));  // R12

   AST_BUSY_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && busy) |=> (pulse == '0));  // R11

   AST_ID_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.id_enter |-> id_mode);  // R7

   AST_ID_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.id_exit |-> !id_mode);  // R8

   AST_PGM_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse.pgm |-> $past(wr_valid));  // R4

endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
   import cmd_seq_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 8,
   parameter int FILT_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              busy,
   output logic              pgm_pulse,
   output logic [ADDR_W-1:0] pgm_addr,
   output logic [DATA_W-1:0] pgm_data,
   output logic              erase_pulse,
   output logic              lock_pulse,
   output logic              id_enter_pulse,
   output logic              id_exit_pulse,
   output logic              id_mode
);

   logic              wr_valid;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   pair_hit_t         hit;
   cmd_pulse_t        pulse;

   cmd_strobe_qual #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .FILT_CYCLES (FILT_CYCLES)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   cmd_pair_match #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_match (
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hit     (hit)
   );

   cmd_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .hit      (hit),
      .busy     (busy),
      .pulse    (pulse),
      .pgm_addr (pgm_addr),
      .pgm_data (pgm_data),
      .id_mode  (id_mode)
   );

   assign pgm_pulse      = pulse.pgm;
   assign erase_pulse    = pulse.erase;
   assign lock_pulse     = pulse.lock;
   assign id_enter_pulse = pulse.id_enter;
   assign id_exit_pulse  = pulse.id_exit;

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pgm_pulse && !erase_pulse && !lock_pulse && !id_mode));  // R13

endmodule

// File: tb/cmd_seq_decoder_tb.sv
module cmd_seq_decoder_tb;

   localparam int AW   = 18;
   localparam int DW   = 8;
   localparam int FILT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
   logic          pgm_pulse, erase_pulse, lock_pulse, id_enter_pulse, id_exit_pulse, id_mode;
   logic [AW-1:0] pgm_addr;
   logic [DW-1:0] pgm_data;

   int checks = 0, errors = 0;
   int n_pgm = 0, n_erase = 0, n_lock = 0, n_enter = 0, n_exit = 0, n_multi = 0;
   int b_pgm, b_erase, b_lock, b_enter, b_exit;
   logic [AW-1:0] seen_addr = '0;
   logic [DW-1:0] seen_data = '0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cmd_seq_decoder #(.ADDR_W(AW), .DATA_W(DW), .FILT_CYCLES(FILT)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy),
      .pgm_pulse(pgm_pulse), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
      .erase_pulse(erase_pulse), .lock_pulse(lock_pulse),
      .id_enter_pulse(id_enter_pulse), .id_exit_pulse(id_exit_pulse), .id_mode(id_mode)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (pgm_pulse) begin
            n_pgm++;
            seen_addr = pgm_addr;
            seen_data = pgm_data;
         end
         if (erase_pulse)    n_erase++;
         if (lock_pulse)     n_lock++;
         if (id_enter_pulse) n_enter++;
         if (id_exit_pulse)  n_exit++;
         if ((32'(pgm_pulse) + 32'(erase_pulse) + 32'(lock_pulse) +
              32'(id_enter_pulse) + 32'(id_exit_pulse)) > 1) n_multi++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic snap();
      b_pgm = n_pgm; b_erase = n_erase; b_lock = n_lock; b_enter = n_enter; b_exit = n_exit;
   endtask

   task automatic chk_counts(input string tag, input int p, input int e, input int l,
                             input int en, input int ex);
      chk({tag, " pgm"},   n_pgm - b_pgm, p);
      chk({tag, " erase"}, n_erase - b_erase, e);
      chk({tag, " lock"},  n_lock - b_lock, l);
      chk({tag, " enter"}, n_enter - b_enter, en);
      chk({tag, " exit"},  n_exit - b_exit, ex);
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int hold = FILT, input logic ce_v = 1'b0, input logic oe_v = 1'b1);
      @(negedge clk);
      bus_addr = a; bus_data = d; ce_n = ce_v; oe_n = oe_v; we_n = 1'b0;
      repeat (hold) @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic unlock();
      bus_wr(18'h05555, 8'hAA);
      bus_wr(18'h02AAA, 8'h55);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R13 pulses", {27'd0, pgm_pulse, erase_pulse, lock_pulse, id_enter_pulse, id_exit_pulse}, 32'd0);
      chk("R13 id_mode", id_mode, 1'b0);
   endtask

   task automatic t_program();
      snap();
      unlock();
      bus_wr(18'h05555, 8'hA0);
      bus_wr(18'h1F00A, 8'h3C);
      chk_counts("R4 program", 1, 0, 0, 0, 0);
      chk("R4 pgm_addr", seen_addr, 18'h1F00A);
      chk("R4 pgm_data", seen_data, 8'h3C);
   endtask

   task automatic t_erase();
      snap();
      unlock();
      bus_wr(18'h05555, 8'h80);
      unlock();
      bus_wr(18'h05555, 8'h10);
      chk_counts("R5 erase", 0, 1, 0, 0, 0);
   endtask

   task automatic t_lock();
      snap();
      unlock();
      bus_wr(18'h05555, 8'h80);
      unlock();
      bus_wr(18'h05555, 8'h40);
      chk_counts("R6 lock", 0, 0, 1, 0, 0);
   endtask

   task automatic t_ident();
      snap();
      bus_wr(18'h00123, 8'hF0);
      chk_counts("R8 F0 outside id mode", 0, 0, 0, 0, 0);
      unlock();
      bus_wr(18'h05555, 8'h90);
      chk_counts("R7 enter", 0, 0, 0, 1, 0);
      chk("R7 id_mode set", id_mode, 1'b1);
      snap();
      bus_wr(18'h01234, 8'hF0);
      chk_counts("R8 single exit", 0, 0, 0, 0, 1);
      chk("R8 id_mode clear single", id_mode, 1'b0);
      unlock();
      bus_wr(18'h05555, 8'h90);
      chk("R7 id_mode again", id_mode, 1'b1);
      snap();
      unlock();
      bus_wr(18'h05555, 8'hF0);
      chk_counts("R8 sequence exit", 0, 0, 0, 0, 1);
      chk("R8 id_mode clear seq", id_mode, 1'b0);
   endtask

   task automatic t_abort();
      snap();
      bus_wr(18'h05555, 8'hAA);
      bus_wr(18'h02AAA, 8'h12);
      bus_wr(18'h05555, 8'hA0);
      bus_wr(18'h00100, 8'h77);
      chk_counts("R9 abort", 0, 0, 0, 0, 0);
      unlock();
      bus_wr(18'h05555, 8'h80);
      unlock();
      bus_wr(18'h05555, 8'h33);
      bus_wr(18'h05555, 8'h10);
      chk_counts("R9 abort at sixth", 0, 0, 0, 0, 0);
      t_program();
   endtask

   task automatic t_qual();
      snap();
      unlock();
      bus_wr(18'h05555, 8'hA0);
      bus_wr(18'h00200, 8'h11, FILT, 1'b0, 1'b0);
      chk_counts("R1 oe low", 0, 0, 0, 0, 0);
      bus_wr(18'h00300, 8'h22, FILT, 1'b1, 1'b1);
      chk_counts("R1 ce high", 0, 0, 0, 0, 0);
      bus_wr(18'h00400, 8'h44);
      chk_counts("R1 valid after ignored", 1, 0, 0, 0, 0);
      chk("R1 data", seen_data, 8'h44);
   endtask

   task automatic t_glitch();
      snap();
      unlock();
      bus_wr(18'h05555, 8'h99, FILT - 1);
      bus_wr(18'h05555, 8'hA0);
      bus_wr(18'h00ABC, 8'h5A);
      chk_counts("R2 glitch ignored", 1, 0, 0, 0, 0);
      chk("R2 data", seen_data, 8'h5A);
   endtask

   task automatic t_latch();
      snap();
      unlock();
      bus_wr(18'h05555, 8'hA0);
      @(negedge clk);
      bus_addr = 18'h0AAAA; bus_data = 8'hD1; we_n = 1'b0; oe_n = 1'b1;
      @(negedge clk);
      bus_addr = 18'h0BBBB; ce_n = 1'b0;
      repeat (2) @(negedge clk);
      bus_data = 8'hD2;
      repeat (2) @(negedge clk);
      ce_n = 1'b1; bus_data = 8'hD3; bus_addr = 18'h0CCCC;
      @(negedge clk);
      we_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_counts("R3 latch", 1, 0, 0, 0, 0);
      chk("R3 address at later fall", seen_addr, 18'h0BBBB);
      chk("R3 data at earlier rise", seen_data, 8'hD2);
   endtask

   task automatic t_upper();
      snap();
      bus_wr(18'h35555, 8'hAA);
      bus_wr(18'h3AAAA, 8'h55);
      bus_wr(18'h25555, 8'hA0);
      bus_wr(18'h2FFFF, 8'h01);
      chk_counts("R10 upper ignored", 1, 0, 0, 0, 0);
      chk("R10 full address out", seen_addr, 18'h2FFFF);
      snap();
      bus_wr(18'h01555, 8'hAA);
      bus_wr(18'h02AAA, 8'h55);
      bus_wr(18'h05555, 8'hA0);
      bus_wr(18'h00010, 8'h02);
      chk_counts("R10 bit14 compared", 0, 0, 0, 0, 0);
   endtask

   task automatic t_busy();
      snap();
      busy = 1'b1;
      unlock();
      bus_wr(18'h05555, 8'hA0);
      bus_wr(18'h00020, 8'h66);
      busy = 1'b0;
      chk_counts("R11 busy whole", 0, 0, 0, 0, 0);
      unlock();
      bus_wr(18'h05555, 8'hA0);
      busy = 1'b1;
      bus_wr(18'h00030, 8'h67);
      busy = 1'b0;
      bus_wr(18'h00040, 8'h68);
      chk_counts("R11 busy resets", 0, 0, 0, 0, 0);
   endtask

   initial begin
      t_reset();
      t_program();
      t_erase();
      t_lock();
      t_ident();
      t_abort();
      t_qual();
      t_glitch();
      t_latch();
      t_upper();
      t_busy();
      chk("R12 overlapping pulses", n_multi, 0);
      chk("R12 total pulse cycles", n_pgm + n_erase + n_lock + n_enter + n_exit, 32'd12);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule